// File: doc/BRIEF.md
# Compare-and-Skip Control Unit

This unit provides conditional execution for a processor core that has no conditional branches and no zero, negative or overflow flags. Each instruction slot that leaves decode carries a decoded class, the two compare operands, the low nibble of the buffer pointer, a 4-bit immediate and a flag that marks the slot as a direct-addressing prefix. The unit decides whether the slot may take effect. If it may not, the slot is squashed. An executing compare, pointer test or return-with-skip can arm a squash of the slot that follows it.

Slots arrive on a valid/ready stream and leave on another. The unit holds no slot buffer: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A slot is accepted only on a cycle where `in_valid` and `out_ready` are both high. The internal state advances only on an accepted slot. While the sink holds `out_ready` low, the verdict on the slot that is waiting stays fixed.

A squashed prefix pulls the instruction it modifies into the same squash, so the two are skipped as one unit. A squashed slot never arms a further skip. The skip requested by a return is consumed by the first slot fetched at the return address. No flag register is read when a skip is decided.

Top module: `skip_ctrl`

## Requirements
- R1: Class 2'b01 (compare, skip if unequal) arms a squash of the next accepted slot when in_opa differs from in_opb, and arms nothing when they are equal.
- R2: Class 2'b10 (pointer test) arms a squash of the next accepted slot when in_bnib equals in_imm, and arms nothing otherwise.
- R3: Class 2'b11 (return with skip) always arms a squash, and that squash lands on the next accepted slot, which is the first slot at the return address.
- R4: Class 2'b00 (any other instruction) never arms a squash.
- R5: When a squashed slot has in_prefix=1, the next accepted slot is also squashed, and squashing ends after that slot.
- R6: A squashed slot arms no squash, whatever its class and operands.
- R7: A slot that is not squashed and has in_prefix=1 arms no squash, whatever its class.
- R8: out_valid equals in_valid and in_ready equals out_ready. State changes only on an accepted slot, so out_squash stays stable while no slot is accepted.
- R9: After reset, no squash is pending and the first accepted slot is not squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded slot is present |
| in_ready | output | 1 | The slot is accepted this cycle when valid |
| in_class | input | 2 | Decoded class: 0 other, 1 compare-unequal, 2 pointer test, 3 return with skip |
| in_opa | input | DATA_W | First compare operand |
| in_opb | input | DATA_W | Second compare operand |
| in_bnib | input | NIB_W | Low nibble of the buffer pointer |
| in_imm | input | NIB_W | Immediate for the pointer test |
| in_prefix | input | 1 | This slot is a direct-addressing prefix |
| out_valid | output | 1 | Verdict for the current slot is present |
| out_ready | input | 1 | Sink accepts the verdict |
| out_squash | output | 1 | The current slot must have no architectural effect |

## Verification
The hardest case to reach is a squash that spans a prefix pair while the modified instruction would itself arm a skip, followed by a back-pressure stall. This case shows whether the state carries across the stall and whether the chain stops. The vector table steers a return-with-skip into a prefix and then a compare whose operands differ. Directed tests then hold out_ready low on both squashed and live slots, and also drop in_valid alone. A reset is also applied while a return-with-skip is pending.

// File: rtl/skip_pkg.sv
package skip_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_CMPNE = 2'd1,
    CLS_BTEST = 2'd2,
    CLS_RETSK = 2'd3
  } ins_class_e;
endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
  import skip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  ins_class_e          cls,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  input  logic [NIB_W-1:0]    bnib,
  input  logic [NIB_W-1:0]    imm,
  output logic                want_skip
);
  logic ne_hit;
  logic nib_hit;

  assign ne_hit  = |(opa ^ opb);
  assign nib_hit = (bnib == imm);

  always_comb begin
    unique case (cls)
      CLS_CMPNE: want_skip = ne_hit;
      CLS_BTEST: want_skip = nib_hit;
      CLS_RETSK: want_skip = 1'b1;
      default:   want_skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/skip_seq.sv
module skip_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic is_prefix,
  input  logic want_skip,
  output logic squash
);
  logic arm_q;
  logic pair_q;
  logic arm_d;
  logic pair_d;

  assign squash = arm_q | pair_q;

  always_comb begin
    arm_d  = arm_q;
    pair_d = pair_q;
    if (fire) begin
      if (squash) begin
        arm_d  = 1'b0;
        pair_d = arm_q & is_prefix;
      end else begin
        arm_d  = want_skip & ~is_prefix;
        pair_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      pair_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      pair_q <= pair_d;
    end
  end

  assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && squash && is_prefix && !pair_q) |=> squash);

  assert_no_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && squash && !is_prefix) |=> !squash);

  assert_prefix_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !squash && is_prefix) |=> !squash);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(squash));
endmodule

// File: rtl/skip_ctrl.sv
module skip_ctrl
  import skip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_class,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  input  logic [NIB_W-1:0]  in_bnib,
  input  logic [NIB_W-1:0]  in_imm,
  input  logic              in_prefix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_squash
);
  ins_class_e cls;
  logic       want_skip;
  logic       fire;

  assign cls       = ins_class_e'(in_class);
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign fire      = in_valid & out_ready;

  skip_cond_eval #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_eval (
    .cls      (cls),
    .opa      (in_opa),
    .opb      (in_opb),
    .bnib     (in_bnib),
    .imm      (in_imm),
    .want_skip(want_skip)
  );

  skip_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .is_prefix(in_prefix),
    .want_skip(want_skip),
    .squash   (out_squash)
  );

  assert_cmpne_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_squash && !in_prefix && cls == CLS_CMPNE) |=>
      (out_squash == $past(in_opa != in_opb)));

  assert_btest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_squash && !in_prefix && cls == CLS_BTEST) |=>
      (out_squash == $past(in_bnib == in_imm)));

  assert_retsk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_squash && !in_prefix && cls == CLS_RETSK) |=> out_squash);

  assert_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_squash && cls == CLS_PLAIN) |=> !out_squash);

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |=> !out_squash);
endmodule

// File: tb/skip_ctrl_bench.sv
module skip_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, out_valid, out_ready, out_squash;
  logic [1:0] in_class;
  logic [7:0] in_opa, in_opb;
  logic [3:0] in_bnib, in_imm;
  logic       in_prefix;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  skip_ctrl u_skip_ctrl (.*);

  // {class, opa, opb, bnib, imm, prefix, expected squash of this slot}
  localparam int NV = 20;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0},  // R9 first slot live
    {2'd1, 8'd5, 8'd5, 4'd0, 4'd0, 1'b0, 1'b0},
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0},  // R1 equal: no squash
    {2'd1, 8'd5, 8'd6, 4'd0, 4'd0, 1'b0, 1'b0},
    {2'd1, 8'd1, 8'd2, 4'd0, 4'd0, 1'b0, 1'b1},  // R1 squashed
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0},  // R6 no chain
    {2'd2, 8'd0, 8'd0, 4'd3, 4'd3, 1'b0, 1'b0},
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b1},  // R2 match
    {2'd2, 8'd0, 8'd0, 4'd3, 4'd4, 1'b0, 1'b0},
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0},  // R2 mismatch
    {2'd3, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0},
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b1, 1'b1},  // R3 return target, prefix
    {2'd1, 8'd1, 8'd2, 4'd0, 4'd0, 1'b0, 1'b1},  // R5 pair member
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0},  // R5 ends, R6
    {2'd1, 8'd1, 8'd2, 4'd0, 4'd0, 1'b1, 1'b0},  // live prefix
    {2'd1, 8'd7, 8'd7, 4'd0, 4'd0, 1'b0, 1'b0},  // R7 prefix armed nothing
    {2'd3, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0},
    {2'd2, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b1},  // R3, squashed test
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0},  // R6
    {2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0, 1'b0}   // R4
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] n, input logic [3:0] i, input logic p);
    in_class = c; in_opa = a; in_opb = b; in_bnib = n; in_imm = i; in_prefix = p;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    drive(2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R9 reset state", out_squash, 1'b0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      in_valid = 1'b1; out_ready = 1'b1;
      drive(VEC[k][27:26], VEC[k][25:18], VEC[k][17:10], VEC[k][9:6], VEC[k][5:2], VEC[k][1]);
      #1 chk($sformatf("R1-table vector %0d", k), out_squash, VEC[k][0]);
    end

    // R8 back-pressure on a live compare that will arm
    @(negedge clk);
    drive(2'd1, 8'd1, 8'd2, 4'd0, 4'd0, 1'b0); out_ready = 1'b0;
    #1 chk("R8 in_ready follows out_ready", in_ready, 1'b0);
    chk("R8 out_valid follows in_valid", out_valid, 1'b1);
    repeat (3) begin
      @(negedge clk);
      #1 chk("R8 stalled slot stays live", out_squash, 1'b0);
    end
    @(negedge clk); out_ready = 1'b1;
    #1 chk("R8 live before accept", out_squash, 1'b0);
    @(negedge clk); drive(2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0); out_ready = 1'b0;
    #1 chk("R8 squash after accept", out_squash, 1'b1);
    repeat (2) begin
      @(negedge clk);
      #1 chk("R8 squash held in stall", out_squash, 1'b1);
    end
    // in_valid low with ready high: nothing accepted
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    #1 chk("R8 out_valid low", out_valid, 1'b0);
    @(negedge clk); in_valid = 1'b1;
    #1 chk("R8 squash held without valid", out_squash, 1'b1);
    @(negedge clk);
    #1 chk("R6 squashed slot released", out_squash, 1'b0);

    // R9 reset drops a pending return skip
    drive(2'd3, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0);
    @(negedge clk); drive(2'd0, 8'd0, 8'd0, 4'd0, 4'd0, 1'b0);
    #1 chk("R3 armed by return", out_squash, 1'b1);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R9 pending cleared by reset", out_squash, 1'b0);

    // R4 plain with unequal operands arms nothing
    drive(2'd0, 8'd9, 8'd3, 4'd1, 4'd1, 1'b0);
    @(negedge clk);
    #1 chk("R4 plain class inert", out_squash, 1'b0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule